// File: doc/BRIEF.md
# Configuration Space Access Port Decoder

This block turns host I/O accesses into configuration cycles. Software writes a 32-bit selector to an address port. The selector names a bus, a device, a function and a dword register. Software then reads or writes one of four consecutive data ports. Each data-port access becomes one configuration read or write toward a device-select interface. That cycle carries the device, the function, a byte offset and an access width. The byte offset is the selector's dword field followed by the low two bits of the data port.

The block serves only the local bus, whose number is set by a parameter and defaults to 0. A data access fails if the selector's enable bit is clear, if its two lowest bits are non-zero, or if its bus field names another bus. A failed read returns all-ones of the access width and issues no cycle. A failed write is dropped. When a cycle is issued but no device answers with a presence flag, the read still returns all-ones. Host reads are answered one clock after the read strobe.

Top module: `cfgio_decoder`

## Requirements
- R1: After reset the stored selector is zero, no response is pending and no configuration cycle is requested.
- R2: A 4-byte write (width code 2 or 3) to the address port stores the data unchanged, including its low bits. A 4-byte read of that port returns the stored value with `io_unused` low.
- R3: A 1- or 2-byte write (width code 0 or 1) to the address port leaves the selector unchanged. A 1- or 2-byte read of that port answers with `io_unused` high and data 0xFF or 0xFFFF.
- R4: While selector bit 31 is clear, data-port accesses request no cycle, and reads return all-ones of the access width.
- R5: While selector bits 1:0 are non-zero, data-port accesses request no cycle, and reads return all-ones of the access width.
- R6: While selector bits 23:16 hold a bus other than the served one, data-port accesses request no cycle, and reads return all-ones of the access width.
- R7: A forwarded access raises `cfg_req` in the same cycle as the host strobe. The cycle carries:
  - device = selector bits 15:11;
  - function = selector bits 10:8;
  - offset = {selector bits 7:2, port bits 1:0};
  - the normalised width;
  - `cfg_we` high for writes;
  - write data masked to the access width.
- R8: A forwarded read returns, one cycle later, the device data masked to the access width with the upper bytes zero. If `cfg_present` is low, it returns all-ones of the access width.
- R9: Host writes never produce a response, and a failed write raises no `cfg_req`.
- R10: Accesses to ports outside the address port and the four data ports produce no response and no cycle.
- R11: Width code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. Code 3 is handled as 4 bytes and is forwarded as code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_port | input | 16 | Host I/O port number |
| io_size | input | 2 | Host access width code |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_wdata | input | 32 | Host write data, right-justified |
| io_rvalid | output | 1 | Read response valid |
| io_rdata | output | 32 | Read response data, right-justified |
| io_unused | output | 1 | Response reports the port as unused |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Cycle is a write |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_off | output | 8 | Byte offset in configuration space |
| cfg_size | output | 2 | Normalised width code |
| cfg_wdata | output | 32 | Write data masked to width |
| cfg_present | input | 1 | A device answered the cycle |
| cfg_rdata | input | 32 | Device read data, right-justified |

## Verification
A data-port read answers one cycle late, so its response comes out in the same cycle in which a following write to the address port changes the selector. The bench issues, back to back and with no idle cycle:
- a selector write;
- a data read;
- a second selector write that names another device;
- a second data read.

The first response must carry the first device's data even though the selector is changing in that cycle. The second read must already use the new device and offset. The scoreboard compares each response with the item queued for that exact cycle.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ACC_1B  = 2'd0,
        ACC_2B  = 2'd1,
        ACC_4B  = 2'd2,
        ACC_4BX = 2'd3
    } acc_size_e;

    // Selector layout; the data path decodes these positions.
    typedef struct packed {
        logic       en;
        logic [6:0] rsvd;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] dw;
        logic [1:0] lo;
    } sel_t;

    typedef struct packed {
        logic addr_wr;
        logic addr_rd;
        logic narrow_rd;
        logic data_rd;
        logic fwd;
        logic fwd_we;
    } dec_t;

    function automatic logic [DATA_W-1:0] width_mask(input acc_size_e s);
        logic [DATA_W-1:0] m;
        case (s)
            ACC_1B:  m = {{(DATA_W-8){1'b0}}, 8'hFF};
            ACC_2B:  m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: m = {DATA_W{1'b1}};
        endcase
        return m;
    endfunction

    function automatic acc_size_e norm_size(input acc_size_e s);
        return (s == ACC_4BX) ? ACC_4B : s;
    endfunction

endpackage

// File: rtl/cfgio_addr_reg.sv
module cfgio_addr_reg
    import cfgio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output sel_t              sel_q
);

    typedef struct packed {
        sel_t sel;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel = sel_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;

endmodule

// File: rtl/cfgio_decode.sv
module cfgio_decode
    import cfgio_pkg::*;
#(
    parameter int              PORT_W     = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_BASE = 16'hCFC,
    parameter logic [7:0]      SERVED_BUS = 8'd0
) (
    input  logic [PORT_W-1:0] io_port,
    input  acc_size_e         io_size,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              sel_en,
    input  logic [7:0]        sel_bus,
    input  logic [1:0]        sel_lo,
    output dec_t              dec
);

    localparam int WIN_LSB = 2;

    logic addr_hit;
    logic data_hit;
    logic full_w;
    logic sel_ok;
    logic wr_only;

    always_comb begin
        addr_hit = (io_port == ADDR_PORT);
        data_hit = (io_port[PORT_W-1:WIN_LSB] == DATA_BASE[PORT_W-1:WIN_LSB]);
        full_w   = (io_size == ACC_4B) || (io_size == ACC_4BX);
        sel_ok   = sel_en && (sel_lo == 2'b00) && (sel_bus == SERVED_BUS);
        wr_only  = io_wr && !io_rd;

        dec.addr_wr   = wr_only && addr_hit && full_w;
        dec.addr_rd   = io_rd && addr_hit && full_w;
        dec.narrow_rd = io_rd && addr_hit && !full_w;
        dec.data_rd   = io_rd && data_hit;
        dec.fwd       = (io_rd || io_wr) && data_hit && sel_ok;
        dec.fwd_we    = wr_only && data_hit && sel_ok;
    end

endmodule

// File: rtl/cfgio_resp.sv
module cfgio_resp
    import cfgio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] mask,
    input  sel_t              sel_q,
    input  logic              cfg_present,
    input  logic [DATA_W-1:0] cfg_rdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              unused
);

    typedef struct packed {
        logic              valid;
        logic              unused;
        logic [DATA_W-1:0] data;
    } resp_t;

    resp_t rs_d, rs_q;

    always_comb begin
        rs_d        = '0;
        rs_d.valid  = dec.addr_rd || dec.narrow_rd || dec.data_rd;
        rs_d.unused = dec.narrow_rd;
        if (dec.addr_rd) begin
            rs_d.data = DATA_W'(sel_q);
        end else if (dec.narrow_rd) begin
            rs_d.data = mask;
        end else if (dec.data_rd) begin
            if (dec.fwd && cfg_present) begin
                rs_d.data = cfg_rdata & mask;
            end else begin
                rs_d.data = mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rvalid = rs_q.valid;
    assign rdata  = rs_q.data;
    assign unused = rs_q.unused;

endmodule

// File: rtl/cfgio_decoder.sv
module cfgio_decoder
    import cfgio_pkg::*;
#(
    parameter int                PORT_W     = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT  = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_BASE  = 16'hCFC,
    parameter logic [7:0]        SERVED_BUS = 8'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [31:0]       io_wdata,
    output logic              io_rvalid,
    output logic [31:0]       io_rdata,
    output logic              io_unused,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_fn,
    output logic [7:0]        cfg_off,
    output logic [1:0]        cfg_size,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_present,
    input  logic [31:0]       cfg_rdata
);

    localparam int OFF_W = 8;

    sel_t              sel_q;
    dec_t              dec;
    acc_size_e         size_e;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] addr_q;

    assign size_e = acc_size_e'(io_size);
    assign mask   = width_mask(size_e);
    assign addr_q = DATA_W'(sel_q);

    cfgio_addr_reg u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dec.addr_wr),
        .wdata (io_wdata),
        .sel_q (sel_q)
    );

    cfgio_decode #(
        .PORT_W     (PORT_W),
        .ADDR_PORT  (ADDR_PORT),
        .DATA_BASE  (DATA_BASE),
        .SERVED_BUS (SERVED_BUS)
    ) u_dec (
        .io_port (io_port),
        .io_size (size_e),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .sel_en  (sel_q.en),
        .sel_bus (sel_q.bus),
        .sel_lo  (sel_q.lo),
        .dec     (dec)
    );

    cfgio_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec         (dec),
        .mask        (mask),
        .sel_q       (sel_q),
        .cfg_present (cfg_present),
        .cfg_rdata   (cfg_rdata),
        .rvalid      (io_rvalid),
        .rdata       (io_rdata),
        .unused      (io_unused)
    );

    always_comb begin
        cfg_req   = dec.fwd;
        cfg_we    = dec.fwd_we;
        cfg_dev   = sel_q.dev;
        cfg_fn    = sel_q.fn;
        cfg_off   = OFF_W'({sel_q.dw, io_port[1:0]});
        cfg_size  = norm_size(size_e);
        cfg_wdata = io_wdata & mask;
    end

endmodule

// File: rtl/cfgio_chk.sv
module cfgio_chk #(
    parameter int                PORT_W     = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT  = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_BASE  = 16'hCFC,
    parameter logic [7:0]        SERVED_BUS = 8'd0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PORT_W-1:0] io_port,
    input logic [1:0]        io_size,
    input logic              io_rd,
    input logic              io_wr,
    input logic [31:0]       io_wdata,
    input logic              io_rvalid,
    input logic              io_unused,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [31:0]       addr_q
);

    logic full_w;
    logic in_win;
    logic sel_wr;
    assign full_w = (io_size >= 2'd2);
    assign in_win = (io_port[PORT_W-1:2] == DATA_BASE[PORT_W-1:2]);
    assign sel_wr = io_wr && !io_rd && (io_port == ADDR_PORT) && full_w;

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (addr_q == $past(io_wdata)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(addr_q));

    p_narrow_unused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (io_port == ADDR_PORT) && !full_w) |=> (io_rvalid && io_unused));

    p_need_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> addr_q[31]);

    p_need_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (addr_q[1:0] == 2'b00));

    p_need_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (addr_q[23:16] == SERVED_BUS));

    p_we_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (cfg_req && io_wr));

    p_read_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && in_win) |=> (io_rvalid && !io_unused));

    p_no_write_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_rvalid);

    p_req_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> in_win);

endmodule

bind cfgio_decoder cfgio_chk #(
    .PORT_W     (PORT_W),
    .ADDR_PORT  (ADDR_PORT),
    .DATA_BASE  (DATA_BASE),
    .SERVED_BUS (SERVED_BUS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_port   (io_port),
    .io_size   (io_size),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .io_rvalid (io_rvalid),
    .io_unused (io_unused),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .addr_q    (addr_q)
);

// File: tb/cfgio_decoder_tb.sv
module cfgio_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic        io_rvalid;
    logic [31:0] io_rdata;
    logic        io_unused;
    logic        cfg_req;
    logic        cfg_we;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [7:0]  cfg_off;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic        cfg_present;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] DEV_MAP = 32'h0000_0105;

    always #10 clk = ~clk;

    cfgio_decoder dut_i (
        .clk (clk), .rst_n (rst_n),
        .io_port (io_port), .io_size (io_size), .io_rd (io_rd), .io_wr (io_wr),
        .io_wdata (io_wdata), .io_rvalid (io_rvalid), .io_rdata (io_rdata),
        .io_unused (io_unused), .cfg_req (cfg_req), .cfg_we (cfg_we),
        .cfg_dev (cfg_dev), .cfg_fn (cfg_fn), .cfg_off (cfg_off),
        .cfg_size (cfg_size), .cfg_wdata (cfg_wdata),
        .cfg_present (cfg_present), .cfg_rdata (cfg_rdata)
    );

    // Device model
    function automatic logic [31:0] dev_data(input logic [4:0] d, input logic [2:0] f,
                                             input logic [7:0] o);
        return {8'h5A, 3'b000, d, 5'b00000, f, o};
    endfunction
    assign cfg_present = cfg_req && DEV_MAP[cfg_dev];
    assign cfg_rdata   = dev_data(cfg_dev, cfg_fn, cfg_off);

    function automatic logic [31:0] ones(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] mk_sel(input logic en, input logic [7:0] bus,
                                           input logic [4:0] d, input logic [2:0] f,
                                           input logic [5:0] dw, input logic [1:0] lo);
        return {en, 7'd0, bus, d, f, dw, lo};
    endfunction

    typedef struct {
        logic        v;
        logic [31:0] d;
        logic        u;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle
    always @(negedge clk) begin
        #1;
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(io_rvalid == e.v, {e.tag, " valid"}, 32'(io_rvalid), 32'(e.v));
            if (e.v) begin
                chk(io_rdata == e.d, {e.tag, " data"}, io_rdata, e.d);
                chk(io_unused == e.u, {e.tag, " unused"}, 32'(io_unused), 32'(e.u));
            end
        end else if (io_rvalid && rst_n) begin
            chk(1'b0, "R9 unexpected response", 32'(io_rvalid), 32'd0);
        end
    end

    // Driver: one access per cycle, starting just after a falling edge
    task automatic acc(input logic [15:0] port, input logic [1:0] sz, input logic rd,
                       input logic wr, input logic [31:0] wd, input logic xreq,
                       input logic [4:0] xdev, input logic [2:0] xfn, input logic [7:0] xoff,
                       input logic xv, input logic [31:0] xd, input logic xu,
                       input string tag);
        exp_t e;
        io_port = port; io_size = sz; io_rd = rd; io_wr = wr; io_wdata = wd;
        #2;
        chk(cfg_req == xreq, {tag, " req"}, 32'(cfg_req), 32'(xreq));
        if (xreq) begin
            chk(cfg_dev == xdev, {tag, " R7 dev"}, 32'(cfg_dev), 32'(xdev));
            chk(cfg_fn == xfn, {tag, " R7 fn"}, 32'(cfg_fn), 32'(xfn));
            chk(cfg_off == xoff, {tag, " R7 off"}, 32'(cfg_off), 32'(xoff));
            chk(cfg_size == ((sz == 2'd3) ? 2'd2 : sz), {tag, " R11 size"},
                32'(cfg_size), 32'((sz == 2'd3) ? 2'd2 : sz));
            chk(cfg_we == (wr && !rd), {tag, " R7 we"}, 32'(cfg_we), 32'(wr && !rd));
            if (wr && !rd)
                chk(cfg_wdata == (wd & ones(sz)), {tag, " R7 wdata"}, cfg_wdata, wd & ones(sz));
        end
        @(posedge clk);
        #1;
        e.v = xv; e.d = xd; e.u = xu; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();
        acc(16'h0000, 2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 5'd0, 3'd0, 8'd0, 1'b0, 32'd0, 1'b0, "idle");
    endtask

    task automatic wr_sel(input logic [31:0] v, input string tag);
        acc(16'hCF8, 2'd2, 1'b0, 1'b1, v, 1'b0, 5'd0, 3'd0, 8'd0, 1'b0, 32'd0, 1'b0, tag);
    endtask

    task automatic rd_sel(input logic [31:0] xv, input string tag);
        acc(16'hCF8, 2'd2, 1'b1, 1'b0, 32'd0, 1'b0, 5'd0, 3'd0, 8'd0, 1'b1, xv, 1'b0, tag);
    endtask

    // Forwarded data read; expected data from the device model or all-ones
    task automatic rd_data(input logic [15:0] port, input logic [1:0] sz,
                           input logic [4:0] d, input logic [2:0] f, input logic [5:0] dw,
                           input string tag);
        logic [7:0]  off;
        logic [31:0] xd;
        off = {dw, port[1:0]};
        xd  = DEV_MAP[d] ? (dev_data(d, f, off) & ones(sz)) : ones(sz);
        acc(port, sz, 1'b1, 1'b0, 32'd0, 1'b1, d, f, off, 1'b1, xd, 1'b0, tag);
    endtask

    task automatic rd_fail(input logic [15:0] port, input logic [1:0] sz, input string tag);
        acc(port, sz, 1'b1, 1'b0, 32'd0, 1'b0, 5'd0, 3'd0, 8'd0, 1'b1, ones(sz), 1'b0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(io_rvalid == 1'b0, "R1 reset rvalid", 32'(io_rvalid), 32'd0);
        chk(cfg_req == 1'b0, "R1 reset req", 32'(cfg_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_sel(32'd0, "R1 selector after reset");

        wr_sel(mk_sel(1, 0, 2, 3, 6'd4, 0), "R2 write selector");
        rd_sel(mk_sel(1, 0, 2, 3, 6'd4, 0), "R2 read selector");
        acc(16'hCF8, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b0, 32'd0, 1'b0, "R3 narrow write");
        acc(16'hCF8, 2'd1, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b0, 32'd0, 1'b0, "R3 half write");
        rd_sel(mk_sel(1, 0, 2, 3, 6'd4, 0), "R3 selector unchanged");
        acc(16'hCF8, 2'd1, 1'b1, 1'b0, 32'd0, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b1, 32'hFFFF, 1'b1, "R3 half read unused");
        acc(16'hCF8, 2'd0, 1'b1, 1'b0, 32'd0, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b1, 32'hFF, 1'b1, "R3 byte read unused");

        rd_data(16'hCFC, 2'd2, 2, 3, 6'd4, "R8 word read");
        rd_data(16'hCFE, 2'd1, 2, 3, 6'd4, "R8 half read at +2");
        rd_data(16'hCFF, 2'd0, 2, 3, 6'd4, "R8 byte read at +3");
        rd_data(16'hCFC, 2'd3, 2, 3, 6'd4, "R11 code 3 read");
        acc(16'hCFD, 2'd0, 1'b0, 1'b1, 32'h1234_56AB, 1'b1, 5'd2, 3'd3, 8'h11,
            1'b0, 32'd0, 1'b0, "R7 byte write");
        acc(16'hCFE, 2'd1, 1'b0, 1'b1, 32'h1234_56AB, 1'b1, 5'd2, 3'd3, 8'h12,
            1'b0, 32'd0, 1'b0, "R7 half write");

        wr_sel(mk_sel(1, 0, 5, 1, 6'd0, 0), "R8 select absent device");
        rd_data(16'hCFC, 2'd1, 5, 1, 6'd0, "R8 absent device ones");

        wr_sel(mk_sel(0, 0, 2, 0, 6'd1, 0), "R4 enable clear");
        rd_fail(16'hCFC, 2'd2, "R4 read fails");
        rd_fail(16'hCFD, 2'd0, "R4 byte read fails");
        acc(16'hCFC, 2'd2, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b0, 32'd0, 1'b0, "R9 failed write dropped");

        wr_sel(mk_sel(1, 0, 2, 0, 6'd1, 2'b01), "R5 low bits set");
        rd_sel(mk_sel(1, 0, 2, 0, 6'd1, 2'b01), "R2 low bits kept");
        rd_fail(16'hCFC, 2'd1, "R5 read fails");

        wr_sel(mk_sel(1, 8'd1, 2, 0, 6'd1, 0), "R6 other bus");
        rd_fail(16'hCFC, 2'd2, "R6 read fails");
        acc(16'hCFC, 2'd2, 1'b0, 1'b1, 32'h1, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b0, 32'd0, 1'b0, "R6 write dropped");

        wr_sel(mk_sel(1, 0, 0, 0, 6'd2, 0), "R10 valid selector");
        acc(16'h0080, 2'd2, 1'b1, 1'b0, 32'd0, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b0, 32'd0, 1'b0, "R10 foreign port read");
        acc(16'hCF9, 2'd2, 1'b1, 1'b0, 32'd0, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b0, 32'd0, 1'b0, "R10 port CF9 read");
        acc(16'hD00, 2'd2, 1'b0, 1'b1, 32'h5, 1'b0, 5'd0, 3'd0, 8'd0,
            1'b0, 32'd0, 1'b0, "R10 port D00 write");

        // Back to back: response of one read lands with the next selector write
        wr_sel(mk_sel(1, 0, 8, 2, 6'd3, 0), "R2 overlap sel A");
        rd_data(16'hCFC, 2'd2, 8, 2, 6'd3, "R8 overlap read A");
        wr_sel(mk_sel(1, 0, 0, 7, 6'd9, 0), "R2 overlap sel B");
        rd_data(16'hCFD, 2'd0, 0, 7, 6'd9, "R7 overlap read B");
        rd_sel(mk_sel(1, 0, 0, 7, 6'd9, 0), "R2 overlap sel B read");
        idle();
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule